// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block sits on the host side of an external parallel NOR flash and runs a complete erase on its own. A single-cycle start request, together with a chip/sector selector and a sector address, launches the six-write command sequence on a simple synchronous memory bus. The bus carries one transfer per cycle, and read data returns in the cycle after the read request. After the final command the block polls the device status register over and over. It reads the status, decides, then reads again. This continues until the device reports completion, a time-limit error, or until a programmable poll budget runs out.

Completion is accepted in two ways: the ready bit (status bit 7) reads as one, or the toggle bit (status bit 6) holds its value across two back-to-back status reads. When the device raises its time-limit flag (status bit 5) while bit 6 is still toggling, the block takes two further confirming reads before it gives up. On any failure it writes the reset command so the device returns to read mode. The host sees a busy level plus one-cycle done and failed pulses.

Top module: `flash_erase_seq`

## Requirements
- R1: Out of reset the block is idle: busy, done, failed and bus request are all low, and the bus stays quiet for as long as busy is low.
- R2: An accepted start produces exactly six write cycles, one per cycle, starting in the cycle after start is sampled: (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), and then either (555h,10h) for a chip erase (chip selector = 1) or (sector address,30h) for a sector erase (chip selector = 0).
- R3: Polling begins right after the last write. Each poll is one read-request cycle at the target address (0 for a chip erase, the latched sector address for a sector erase), then one evaluation cycle in which the returned data is used. The next read follows immediately.
- R4: A status read with bit 7 = 1 ends the operation as a success.
- R5: A status read whose bit 6 equals bit 6 of the previous read in the same operation ends the operation as a success. The first read of an operation never completes through bit 6.
- R6: A read that is not complete, has a previous read, and shows bit 5 = 1 arms a confirmation. Two more reads follow. If either of them completes, the result is success. If the second of them is also incomplete, the operation fails.
- R7: The poll limit is latched at start. If the read that brings the read count up to that limit is not complete, the operation fails.
- R8: On failure the block issues exactly one write of F0h to address 0, in the cycle after the failing evaluation. The failed pulse follows in the next cycle.
- R9: Done and failed are one-cycle pulses, never high together. Both appear in the cycle after the operation ends (the completing evaluation or the abort write), and busy is already low in that cycle. Busy is high from the cycle after start up to that point.
- R10: A start request while busy is high is ignored: it changes neither the write sequence, the read address nor the outcome.
- R11: Completion takes priority over a bit-5 indication and over the poll limit within the same read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle erase request |
| chip_i | input | 1 | 1 = whole-chip erase, 0 = sector erase |
| sector_addr_i | input | ADDR_W | Sector address for a sector erase |
| poll_limit_i | input | WDOG_W | Maximum number of status reads |
| bus_req_o | output | 1 | Bus transfer request this cycle |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Write data byte |
| bus_rdata_i | input | 3 | Read data bits 7..5 (ready, toggle, time-limit), valid in the cycle after a read request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
Counting cycles from the first cycle after start is sampled as cycle 1, the writes fall in cycles 1 to 6. The i-th read (counted from 0) is requested in cycle 7+2i. With R reads in total, done arrives in cycle 7+2R. On failure the abort write falls in cycle 7+2R and failed arrives in cycle 8+2R. The bench's device model stamps every bus transfer with its cycle number. The bench compares each stamp and each pulse cycle against these formulas at the falling edge, over a sweep of both erase kinds, five status patterns and several completion points.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD,
        ST_EVAL,
        ST_ABORT
    } seq_state_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

    localparam int CMD_STEPS    = 6;
    localparam int CONFIRM_READS = 2;

    localparam int BIT_READY  = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [2:0]        step_i,
    input  logic              chip_i,
    input  logic [ADDR_W-1:0] sector_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o
);

    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

    always_comb begin
        case (step_i)
            3'd0, 3'd3: begin
                addr_o = ADDR_A;
                data_o = CMD_KEY_A;
            end
            3'd1, 3'd4: begin
                addr_o = ADDR_B;
                data_o = CMD_KEY_B;
            end
            3'd2: begin
                addr_o = ADDR_A;
                data_o = CMD_SETUP;
            end
            default: begin
                addr_o = chip_i ? ADDR_A : sector_i;
                data_o = chip_i ? CMD_CHIP : CMD_SECTOR;
            end
        endcase
    end

endmodule

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
    parameter int WDOG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic [WDOG_W-1:0] limit_i,
    output logic              expire_o
);

    logic [WDOG_W-1:0] count_d, count_q;
    logic [WDOG_W:0]   next_cnt;

    always_comb begin
        next_cnt = {1'b0, count_q} + 1'b1;
        expire_o = tick_i && (next_cnt >= {1'b0, limit_i});
        count_d  = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (tick_i && !next_cnt[WDOG_W]) begin
            count_d = next_cnt[WDOG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval
    import flash_erase_pkg::*;
(
    input  logic [7:5] status_i,
    input  logic       have_prev_i,
    input  logic       prev_tog_i,
    input  logic [1:0] confirm_i,
    input  logic       wdog_hit_i,
    output logic       complete_o,
    output logic       arm_o,
    output logic       fail_o
);

    logic tog_still;
    logic last_confirm;

    always_comb begin
        tog_still    = have_prev_i && (status_i[BIT_TOGGLE] != prev_tog_i);
        complete_o   = status_i[BIT_READY] ||
                       (have_prev_i && (status_i[BIT_TOGGLE] == prev_tog_i));
        last_confirm = (confirm_i == 2'd1);
        arm_o        = !complete_o && tog_still && status_i[BIT_LIMIT] &&
                       (confirm_i == 2'd0);
        fail_o       = !complete_o && (last_confirm || wdog_hit_i);
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WDOG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chip_i,
    input  logic [ADDR_W-1:0] sector_addr_i,
    input  logic [WDOG_W-1:0] poll_limit_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic [7:5]        bus_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);

    localparam logic [2:0] LAST_STEP = 3'(CMD_STEPS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        step;
        logic              chip;
        logic [ADDR_W-1:0] addr;
        logic [WDOG_W-1:0] limit;
        logic              have_prev;
        logic              prev_tog;
        logic [1:0]        confirm;
        logic              done;
        logic              fail;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_data;
    logic              ev_complete, ev_arm, ev_fail;
    logic              wd_clear, wd_tick, wd_hit;

    flash_cmd_rom #(.ADDR_W(ADDR_W)) u_rom (
        .step_i   (r_q.step),
        .chip_i   (r_q.chip),
        .sector_i (r_q.addr),
        .addr_o   (rom_addr),
        .data_o   (rom_data)
    );

    assign wd_clear = (r_q.st == ST_IDLE) && start_i;
    assign wd_tick  = (r_q.st == ST_EVAL);

    flash_poll_wdog #(.WDOG_W(WDOG_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (wd_clear),
        .tick_i   (wd_tick),
        .limit_i  (r_q.limit),
        .expire_o (wd_hit)
    );

    flash_status_eval u_eval (
        .status_i    (bus_rdata_i),
        .have_prev_i (r_q.have_prev),
        .prev_tog_i  (r_q.prev_tog),
        .confirm_i   (r_q.confirm),
        .wdog_hit_i  (wd_hit),
        .complete_o  (ev_complete),
        .arm_o       (ev_arm),
        .fail_o      (ev_fail)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_CMD;
                    r_d.step      = '0;
                    r_d.chip      = chip_i;
                    r_d.addr      = sector_addr_i;
                    r_d.limit     = poll_limit_i;
                    r_d.have_prev = 1'b0;
                    r_d.prev_tog  = 1'b0;
                    r_d.confirm   = '0;
                end
            end
            ST_CMD: begin
                if (r_q.step == LAST_STEP) r_d.st = ST_RD;
                else                       r_d.step = r_q.step + 3'd1;
            end
            ST_RD: begin
                r_d.st = ST_EVAL;
            end
            ST_EVAL: begin
                r_d.have_prev = 1'b1;
                r_d.prev_tog  = bus_rdata_i[BIT_TOGGLE];
                if (ev_complete) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (ev_fail) begin
                    r_d.st = ST_ABORT;
                end else begin
                    r_d.st = ST_RD;
                    if (ev_arm)                 r_d.confirm = 2'(CONFIRM_READS);
                    else if (r_q.confirm != 0)  r_d.confirm = r_q.confirm - 2'd1;
                end
            end
            ST_ABORT: begin
                r_d.st   = ST_IDLE;
                r_d.fail = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o      = (r_q.st != ST_IDLE);
        done_o      = r_q.done;
        fail_o      = r_q.fail;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        case (r_q.st)
            ST_CMD: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = rom_addr;
                bus_wdata_o = rom_data;
            end
            ST_RD: begin
                bus_req_o  = 1'b1;
                bus_addr_o = r_q.chip ? '0 : r_q.addr;
            end
            ST_ABORT: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_wdata_o = CMD_RESET;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [7:0]        bus_wdata_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    p_read_then_eval_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_we_o) |=> !bus_req_o);

    p_abort_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && bus_wdata_o == 8'hF0 && bus_addr_o == '0) |=> fail_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);

    p_not_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_end_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !busy_o);

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
);

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;

    localparam int ADDR_W = 20;
    localparam int WDOG_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              chip = 1'b0;
    logic [ADDR_W-1:0] sector = '0;
    logic [WDOG_W-1:0] limit = '0;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        rdata = '0;
    logic              busy, done, fail;

    always #10 clk = ~clk;

    flash_erase_seq #(.ADDR_W(ADDR_W), .WDOG_W(WDOG_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .chip_i        (chip),
        .sector_addr_i (sector),
        .poll_limit_i  (limit),
        .bus_req_o     (bus_req),
        .bus_we_o      (bus_we),
        .bus_addr_o    (bus_addr),
        .bus_wdata_o   (bus_wdata),
        .bus_rdata_i   (rdata[7:5]),
        .busy_o        (busy),
        .done_o        (done),
        .fail_o        (fail)
    );

    int checks = 0;
    int errors = 0;

    // device model state
    int cyc = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int rd_base = 0;
    int rd_addr_err = 0;
    int rd_cyc_err = 0;
    int rd_c1 = 0;
    logic [ADDR_W-1:0] exp_rd_addr = '0;
    logic [ADDR_W-1:0] wr_addr [0:63];
    logic [7:0]        wr_data [0:63];
    int                wr_cyc  [0:63];
    int mode = 0;
    int kk = 1;

    function automatic logic [7:0] stat(input int n);
        logic tog;
        logic [7:0] s;
        tog = n[0];
        s = {1'b0, tog, 6'b0};
        case (mode)
            0: if (n >= kk) s[7] = 1'b1;
            1: if (n >= kk) s[6] = logic'((kk - 1) & 1);
            2: if (n >= kk) s[5] = 1'b1;
            3: begin
                if (n >= kk) s[5] = 1'b1;
                if (n >= kk + 1) s[6] = logic'(kk & 1);
            end
            default: ;
        endcase
        return s;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_req && bus_we) begin
            wr_addr[wr_cnt[5:0]] <= bus_addr;
            wr_data[wr_cnt[5:0]] <= bus_wdata;
            wr_cyc[wr_cnt[5:0]]  <= cyc;
            wr_cnt <= wr_cnt + 1;
        end
        if (bus_req && !bus_we) begin
            rdata <= stat(rd_cnt - rd_base);
            if (bus_addr != exp_rd_addr) rd_addr_err <= rd_addr_err + 1;
            if (cyc != rd_c1 + 6 + 2 * (rd_cnt - rd_base)) rd_cyc_err <= rd_cyc_err + 1;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (mode %0d k %0d chip %0b)",
                     req, what, act, exp, mode, kk, chip);
        end
    endtask

    task automatic run_case(input bit c, input int m, input int k);
        int wbase, c1, reads_exp, pulse_cyc, seen_cyc, waited;
        bit exp_fail, got_done, got_fail;
        logic [ADDR_W-1:0] sec;
        logic [7:0] ed;
        logic [ADDR_W-1:0] ea;
        int lim;
        mode = m;
        kk = k;
        sec = ADDR_W'(32'h3_4000 + k * 16 + m);
        lim = 100;
        case (m)
            0: begin reads_exp = k + 1; exp_fail = 0; lim = k + 1; end
            1: begin reads_exp = k + 1; exp_fail = 0; end
            2: begin reads_exp = k + 3; exp_fail = 1; end
            3: begin reads_exp = k + 2; exp_fail = 0; end
            default: begin reads_exp = k + 1; exp_fail = 1; lim = k + 1; end
        endcase
        @(negedge clk);
        chip = c;
        sector = sec;
        limit = WDOG_W'(lim);
        exp_rd_addr = c ? '0 : sec;
        rd_base = rd_cnt;
        wbase = wr_cnt;
        rd_addr_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c1 = cyc;
        rd_c1 = c1;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        // R10: a second start while busy, with other settings
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        chip = ~c;
        sector = ~sec;
        limit = 8'd1;
        @(negedge clk);
        start = 1'b0;
        got_done = 0;
        got_fail = 0;
        seen_cyc = 0;
        waited = 0;
        while (!done && !fail && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        got_done = done;
        got_fail = fail;
        seen_cyc = cyc;
        pulse_cyc = exp_fail ? c1 + 7 + 2 * reads_exp : c1 + 6 + 2 * reads_exp;
        chk(got_done == !exp_fail && got_fail == exp_fail,
            exp_fail ? (m == 2 ? "R6" : "R7") : (m == 0 ? "R4" : (m == 1 ? "R5" : "R6")),
            "outcome done/fail", {got_done, got_fail}, {!exp_fail, exp_fail});
        chk(seen_cyc == pulse_cyc, "R9", "pulse cycle", seen_cyc - c1, pulse_cyc - c1);
        chk(busy == 1'b0, "R9", "busy in pulse cycle", busy, 0);
        chk(rd_cnt - rd_base == reads_exp, m == 0 ? "R11" : "R3", "read count",
            rd_cnt - rd_base, reads_exp);
        chk(rd_addr_err == 0 && rd_cyc_err == 0, "R3", "read address/cycle errors",
            rd_addr_err + rd_cyc_err, 0);
        chk(wr_cnt - wbase == (exp_fail ? 7 : 6), "R10", "write count",
            wr_cnt - wbase, exp_fail ? 7 : 6);
        for (int i = 0; i < 6; i++) begin
            case (i)
                0, 3: begin ea = ADDR_W'(12'h555); ed = 8'hAA; end
                1, 4: begin ea = ADDR_W'(12'h2AA); ed = 8'h55; end
                2:    begin ea = ADDR_W'(12'h555); ed = 8'h80; end
                default: begin
                    ea = c ? ADDR_W'(12'h555) : sec;
                    ed = c ? 8'h10 : 8'h30;
                end
            endcase
            chk(wr_addr[(wbase + i) % 64] == ea && wr_data[(wbase + i) % 64] == ed &&
                wr_cyc[(wbase + i) % 64] == c1 + i, "R2", "command write",
                {wr_addr[(wbase + i) % 64], wr_data[(wbase + i) % 64]}, {ea, ed});
        end
        if (exp_fail) begin
            chk(wr_addr[(wbase + 6) % 64] == '0 && wr_data[(wbase + 6) % 64] == 8'hF0 &&
                wr_cyc[(wbase + 6) % 64] == c1 + 6 + 2 * reads_exp, "R8", "abort write",
                {wr_addr[(wbase + 6) % 64], wr_data[(wbase + 6) % 64]}, 8'hF0);
        end
        @(negedge clk);
        chk(!done && !fail && !busy && !bus_req, "R9", "pulse one cycle",
            {done, fail, busy, bus_req}, 0);
    endtask

    initial begin
        #(20ns * 190000);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !bus_req, "R1", "reset state",
            {busy, done, fail, bus_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && wr_cnt == 0 && rd_cnt == 0, "R1", "idle after reset",
            wr_cnt + rd_cnt, 0);
        for (int c = 0; c < 2; c++)
            for (int m = 0; m < 5; m++)
                for (int k = 1; k <= 4; k++)
                    run_case(c[0], m, k);
        repeat (4) @(negedge clk);
        chk(!busy && !bus_req, "R1", "quiet at end", {busy, bus_req}, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule